// File: doc/BRIEF.md
# Interrupt Entry Frame Sequencer

This block carries out the automatic part of a processor's response once an interrupt has been accepted. On a one-cycle accept strobe it captures several values: the interrupt level, the vector number, the current status word, the program counter and both supervisor stack pointers. It then pushes a four-word exception frame through a 16-bit write port that uses a valid/ready handshake. When the last word has been taken, it presents the modified status word, the updated stack pointers and the byte address of the vector table entry, and pulses a done flag for one cycle.

The stacks grow toward lower addresses. Each 16-bit word is stored two bytes below the previous one. The format/vector word goes first, then the low half of the program counter, then the high half, then the saved status word. The frame therefore reads upward from its lowest address as: status, PC high, PC low, format/vector.

The status-word bit that selects the stack is called the stack-select bit (bit 12).
- When it is set at entry, the core is running on the master stack. The block then writes one frame onto the master stack and a second frame onto the interrupt stack, which becomes the active stack.
- When it is clear, the entry is nested. Only one frame is written, onto the interrupt stack, and no stack switch takes place.

Top module: `irq_frame_seq`

## Requirements
- R1: After reset, wr_valid_o, done_o and busy_o are 0, and sr_o, msp_o, isp_o and vec_addr_o are 0.
- R2: Each frame is written with four 16-bit words, each at an address two below the previous one, starting two below the stack pointer. Relative to the frame's final (lowest) address F, the word order and positions are:
  - format/vector at F+6
  - PC bits 15:0 at F+4
  - PC bits 31:16 at F+2
  - saved status at F+0
- R3: The format/vector word has bits 15:12 = 0 and bits 11:0 = vector number times 4.
- R4: The status word stored in the frame is the value presented at accept, before any entry modification.
- R5: The resulting status word sr_o has the following changes, with every other bit kept from the input:
  - bits 15 and 14 (trace) cleared
  - bit 13 (supervisor) set
  - bit 12 (stack select) cleared
  - bits 10:8 (mask) equal to the interrupt level
- R6: When input status bit 12 is 1, the first frame goes below msp_i and the second frame goes below isp_i. The results are msp_o = msp_i − 8 and isp_o = isp_i − 8.
- R7: When input status bit 12 is 0, exactly one frame is written below isp_i. The results are isp_o = isp_i − 8 and msp_o = msp_i.
- R8: While wr_valid_o is high and wr_ready_i is low, wr_valid_o, wr_addr_o and wr_data_o hold their values into the next cycle. A word counts as written only on a cycle with both valid and ready high.
- R9: done_o is high for exactly one cycle, the cycle after the final write is accepted. sr_o, msp_o, isp_o and vec_addr_o take their new values in that same cycle and hold them until the next entry completes.
- R10: vec_addr_o equals the vector number shifted left by 2, zero-extended.
- R11: An accept strobe that arrives while busy_o is high is ignored: it causes no extra writes and no change to any result.
- R12: busy_o is high from the cycle after an accepted strobe through the done cycle inclusive. It is low otherwise, and no write is requested while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| accept_i | input | 1 | One-cycle strobe: an interrupt has been accepted |
| level_i | input | 3 | Level of the accepted interrupt |
| vector_i | input | 8 | Vector number |
| sr_i | input | 16 | Status word at the time of acceptance |
| pc_i | input | 32 | Program counter to save |
| msp_i | input | 32 | Master stack pointer |
| isp_i | input | 32 | Interrupt stack pointer |
| wr_valid_o | output | 1 | Write request |
| wr_addr_o | output | 32 | Byte address of the 16-bit word |
| wr_data_o | output | 16 | Word to write |
| wr_ready_i | input | 1 | Memory accepts the word this cycle |
| busy_o | output | 1 | Sequencer is running an entry |
| done_o | output | 1 | One-cycle completion pulse |
| sr_o | output | 16 | Status word after entry |
| msp_o | output | 32 | Master stack pointer after entry |
| isp_o | output | 32 | Interrupt stack pointer after entry |
| vec_addr_o | output | 32 | Byte address of the vector table entry |

## Verification
The hardest situation to reach is an outermost entry whose eight writes are broken up by ready stalls. Reaching it also exercises the switch from the master stack to the interrupt stack between frames while a word is being held. The bench sets the stack-select bit in the input status word and drives ready low two cycles out of three, so stalls fall on words inside both frames, including the last word of the first frame. A second accept strobe is also injected in the middle of a running entry, with a different vector and stack pointer, so that any leak would show up in the write log or in the results.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    // status word bit positions
    localparam int SR_TRACE_HI = 15;
    localparam int SR_TRACE_LO = 14;
    localparam int SR_SUPV     = 13;
    localparam int SR_STKSEL   = 12;
    localparam int SR_MASK_LO  = 8;

    localparam logic [3:0] FRAME_FMT = 4'h0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    // push order within one frame
    typedef enum logic [1:0] {
        W_FMTVEC = 2'd0,
        W_PC_LO  = 2'd1,
        W_PC_HI  = 2'd2,
        W_STATUS = 2'd3
    } word_sel_e;

endpackage

// File: rtl/irq_sr_update.sv
module irq_sr_update
    import irq_seq_pkg::*;
#(
    parameter int DW      = 16,
    parameter int LEVEL_W = 3
) (
    input  logic [DW-1:0]      sr_i,
    input  logic [LEVEL_W-1:0] level_i,
    output logic [DW-1:0]      sr_o
);
    always_comb begin
        sr_o = sr_i;
        sr_o[SR_TRACE_HI] = 1'b0;
        sr_o[SR_TRACE_LO] = 1'b0;
        sr_o[SR_SUPV]     = 1'b1;
        sr_o[SR_STKSEL]   = 1'b0;
        sr_o[SR_MASK_LO +: LEVEL_W] = level_i;
    end
endmodule

// File: rtl/irq_frame_word.sv
module irq_frame_word
    import irq_seq_pkg::*;
#(
    parameter int DW    = 16,
    parameter int PC_W  = 32,
    parameter int VEC_W = 8
) (
    input  logic [1:0]       sel_i,
    input  logic [DW-1:0]    sr_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic [DW-1:0]    data_o
);
    localparam int OFS_W = DW - 4;

    logic [OFS_W-1:0] vec_ofs;
    assign vec_ofs = {{(OFS_W-VEC_W-2){1'b0}}, vec_i, 2'b00};

    always_comb begin
        unique case (word_sel_e'(sel_i))
            W_FMTVEC: data_o = {FRAME_FMT, vec_ofs};
            W_PC_LO:  data_o = pc_i[DW-1:0];
            W_PC_HI:  data_o = pc_i[PC_W-1:DW];
            W_STATUS: data_o = sr_i;
            default:  data_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_stack_select.sv
module irq_stack_select #(
    parameter int AW = 32
) (
    // entry-time choice of first stack
    input  logic          entry_outer_i,
    input  logic [AW-1:0] entry_msp_i,
    input  logic [AW-1:0] entry_isp_i,
    output logic [AW-1:0] entry_sp_o,
    // captured context
    input  logic          outer_i,
    input  logic          frame_i,
    input  logic [AW-1:0] msp_i,
    input  logic [AW-1:0] isp_i,
    output logic          last_frame_o,
    output logic [AW-1:0] msp_final_o,
    output logic [AW-1:0] isp_final_o
);
    localparam logic [AW-1:0] FRAME_BYTES = AW'(8);

    assign entry_sp_o   = entry_outer_i ? entry_msp_i : entry_isp_i;
    assign last_frame_o = outer_i ? frame_i : 1'b1;
    assign msp_final_o  = outer_i ? (msp_i - FRAME_BYTES) : msp_i;
    assign isp_final_o  = isp_i - FRAME_BYTES;
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
    import irq_seq_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LEVEL_W = 3,
    parameter int VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept_i,
    input  logic [LEVEL_W-1:0] level_i,
    input  logic [VEC_W-1:0]   vector_i,
    input  logic [15:0]        sr_i,
    input  logic [31:0]        pc_i,
    input  logic [AW-1:0]      msp_i,
    input  logic [AW-1:0]      isp_i,
    output logic               wr_valid_o,
    output logic [AW-1:0]      wr_addr_o,
    output logic [15:0]        wr_data_o,
    input  logic               wr_ready_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [15:0]        sr_o,
    output logic [AW-1:0]      msp_o,
    output logic [AW-1:0]      isp_o,
    output logic [AW-1:0]      vec_addr_o
);
    localparam int DW   = 16;
    localparam int PC_W = 2 * DW;
    localparam int FRAME_WORDS = 4;
    localparam logic [1:0] LAST_WORD = 2'(FRAME_WORDS - 1);
    localparam logic [AW-1:0] WORD_BYTES = AW'(DW / 8);

    typedef struct packed {
        seq_state_e         st;
        logic               outer;
        logic               frame;
        logic [1:0]         word;
        logic [AW-1:0]      sp;
        logic [LEVEL_W-1:0] lvl;
        logic [VEC_W-1:0]   vec;
        logic [DW-1:0]      sr;
        logic [PC_W-1:0]    pc;
        logic [AW-1:0]      msp;
        logic [AW-1:0]      isp;
        logic [DW-1:0]      sr_res;
        logic [AW-1:0]      msp_res;
        logic [AW-1:0]      isp_res;
        logic [AW-1:0]      vec_res;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [DW-1:0] sr_new;
    logic [DW-1:0] word_data;
    logic [AW-1:0] entry_sp;
    logic          last_frame;
    logic [AW-1:0] msp_fin;
    logic [AW-1:0] isp_fin;
    logic [AW-1:0] vec_addr;
    logic          push_ack;

    irq_sr_update #(.DW(DW), .LEVEL_W(LEVEL_W)) u_sr (
        .sr_i    (seq_q.sr),
        .level_i (seq_q.lvl),
        .sr_o    (sr_new)
    );

    irq_frame_word #(.DW(DW), .PC_W(PC_W), .VEC_W(VEC_W)) u_word (
        .sel_i  (seq_q.word),
        .sr_i   (seq_q.sr),
        .pc_i   (seq_q.pc),
        .vec_i  (seq_q.vec),
        .data_o (word_data)
    );

    irq_stack_select #(.AW(AW)) u_stk (
        .entry_outer_i (sr_i[SR_STKSEL]),
        .entry_msp_i   (msp_i),
        .entry_isp_i   (isp_i),
        .entry_sp_o    (entry_sp),
        .outer_i       (seq_q.outer),
        .frame_i       (seq_q.frame),
        .msp_i         (seq_q.msp),
        .isp_i         (seq_q.isp),
        .last_frame_o  (last_frame),
        .msp_final_o   (msp_fin),
        .isp_final_o   (isp_fin)
    );

    assign vec_addr = {{(AW-VEC_W-2){1'b0}}, seq_q.vec, 2'b00};
    assign push_ack = (seq_q.st == ST_PUSH) && wr_ready_i;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (accept_i) begin
                    seq_d.st    = ST_PUSH;
                    seq_d.outer = sr_i[SR_STKSEL];
                    seq_d.frame = 1'b0;
                    seq_d.word  = '0;
                    seq_d.sp    = entry_sp;
                    seq_d.lvl   = level_i;
                    seq_d.vec   = vector_i;
                    seq_d.sr    = sr_i;
                    seq_d.pc    = pc_i;
                    seq_d.msp   = msp_i;
                    seq_d.isp   = isp_i;
                end
            end
            ST_PUSH: begin
                if (push_ack) begin
                    seq_d.sp = seq_q.sp - WORD_BYTES;
                    if (seq_q.word == LAST_WORD) begin
                        seq_d.word = '0;
                        if (last_frame) begin
                            seq_d.st      = ST_DONE;
                            seq_d.sr_res  = sr_new;
                            seq_d.msp_res = msp_fin;
                            seq_d.isp_res = isp_fin;
                            seq_d.vec_res = vec_addr;
                        end else begin
                            seq_d.frame = 1'b1;
                            seq_d.sp    = seq_q.isp;
                        end
                    end else begin
                        seq_d.word = seq_q.word + 2'd1;
                    end
                end
            end
            ST_DONE: seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign wr_valid_o = (seq_q.st == ST_PUSH);
    assign wr_addr_o  = seq_q.sp - WORD_BYTES;
    assign wr_data_o  = word_data;
    assign busy_o     = (seq_q.st != ST_IDLE);
    assign done_o     = (seq_q.st == ST_DONE);
    assign sr_o       = seq_q.sr_res;
    assign msp_o      = seq_q.msp_res;
    assign isp_o      = seq_q.isp_res;
    assign vec_addr_o = seq_q.vec_res;
endmodule

// File: rtl/irq_frame_seq_chk.sv
module irq_frame_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid_o,
    input logic          wr_ready_i,
    input logic [AW-1:0] wr_addr_o,
    input logic [15:0]   wr_data_o,
    input logic          busy_o,
    input logic          done_o,
    input logic [15:0]   sr_o,
    input logic [AW-1:0] msp_o,
    input logic [AW-1:0] isp_o
);
    // R8
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=>
            (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done_o || ($stable(sr_o) && $stable(msp_o) && $stable(isp_o))));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!wr_valid_o && !done_o));

    // R5
    sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sr_o[15:14] == 2'b00 && sr_o[13] && !sr_o[12]));

    // R9
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(wr_valid_o && wr_ready_i));
endmodule

bind irq_frame_seq irq_frame_seq_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sr_o       (sr_o),
    .msp_o      (msp_o),
    .isp_o      (isp_o)
);

// File: tb/tb_irq_frame_seq.sv
`timescale 1ns/1ps
module tb_irq_frame_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        accept = 1'b0;
    logic [2:0]  level = '0;
    logic [7:0]  vector = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] pc = '0;
    logic [31:0] msp_in = '0;
    logic [31:0] isp_in = '0;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [15:0] wr_data;
    logic        wr_ready = 1'b1;
    logic        busy, done;
    logic [15:0] sr_out;
    logic [31:0] msp_out, isp_out, vec_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irq_frame_seq dut (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .level_i(level),
        .vector_i(vector), .sr_i(sr_in), .pc_i(pc), .msp_i(msp_in), .isp_i(isp_in),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .wr_ready_i(wr_ready), .busy_o(busy), .done_o(done), .sr_o(sr_out),
        .msp_o(msp_out), .isp_o(isp_out), .vec_addr_o(vec_addr)
    );

    // write log
    logic [31:0] log_a [0:15];
    logic [15:0] log_d [0:15];
    int log_n = 0;
    always @(posedge clk) begin
        if (wr_valid && wr_ready && log_n < 16) begin
            log_a[log_n] = wr_addr;
            log_d[log_n] = wr_data;
            log_n++;
        end
    end

    // ready pattern and hold monitor
    bit stall_en = 0;
    int cyc = 0;
    bit prev_stall = 0;
    logic [31:0] prev_a;
    logic [15:0] prev_d;
    int hold_bad = 0;
    int stall_seen = 0;
    always @(negedge clk) begin
        if (prev_stall && (!wr_valid || wr_addr != prev_a || wr_data != prev_d))
            hold_bad++;
        cyc++;
        wr_ready = stall_en ? (cyc % 3 == 2) : 1'b1;
        prev_stall = wr_valid && !wr_ready;
        if (prev_stall) stall_seen++;
        prev_a = wr_addr;
        prev_d = wr_data;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_sr(input logic [15:0] s, input logic [2:0] l);
        logic [15:0] r;
        r = s;
        r[15] = 1'b0; r[14] = 1'b0; r[13] = 1'b1; r[12] = 1'b0;
        r[10:8] = l;
        return r;
    endfunction

    task automatic start_entry(input logic [2:0] l, input logic [7:0] v,
                               input logic [15:0] s, input logic [31:0] p,
                               input logic [31:0] m, input logic [31:0] i);
        @(negedge clk);
        level = l; vector = v; sr_in = s; pc = p; msp_in = m; isp_in = i;
        log_n = 0;
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
    endtask

    // returns negedge count since accept was driven
    task automatic wait_done(output int n);
        n = 1;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_frame(input int b, input logic [31:0] fin,
                               input logic [15:0] s, input logic [31:0] p,
                               input logic [7:0] v, input string req);
        chk(log_a[b] == fin + 6,   req, "fmt addr",  log_a[b],   fin + 6);
        chk(log_d[b] == {4'h0, 2'b00, v, 2'b00}, "R3", "fmt word", log_d[b], {4'h0, 2'b00, v, 2'b00});
        chk(log_a[b+1] == fin + 4 && log_d[b+1] == p[15:0], req, "pc lo", log_d[b+1], p[15:0]);
        chk(log_a[b+2] == fin + 2 && log_d[b+2] == p[31:16], req, "pc hi", log_d[b+2], p[31:16]);
        chk(log_a[b+3] == fin && log_d[b+3] == s, "R4", "saved sr", log_d[b+3], s);
    endtask

    task automatic t_reset();
        chk(!wr_valid && !done && !busy, "R1", "idle outputs", {wr_valid, done, busy}, 0);
        chk(sr_out == 0 && msp_out == 0 && isp_out == 0 && vec_addr == 0, "R1",
            "result regs", sr_out, 0);
    endtask

    task automatic t_nested_fast();
        int n;
        stall_en = 0;
        start_entry(3'd5, 8'h40, 16'h2304, 32'h1234_5678, 32'h0000_1000, 32'h0000_2000);
        chk(busy == 1'b1, "R12", "busy after accept", busy, 1);
        wait_done(n);
        chk(n == 5, "R9", "nested done cycle", n, 5);
        chk(log_n == 4, "R7", "nested write count", log_n, 4);
        check_frame(0, 32'h0000_1FF8, 16'h2304, 32'h1234_5678, 8'h40, "R2");
        chk(sr_out == exp_sr(16'h2304, 3'd5), "R5", "new sr", sr_out, exp_sr(16'h2304, 3'd5));
        chk(msp_out == 32'h1000 && isp_out == 32'h1FF8, "R7", "nested pointers", isp_out, 32'h1FF8);
        chk(vec_addr == 32'h100, "R10", "vector address", vec_addr, 32'h100);
        @(negedge clk);
        chk(!done && !busy, "R9", "done single pulse", {done, busy}, 0);
        chk(sr_out == exp_sr(16'h2304, 3'd5), "R9", "result held", sr_out, exp_sr(16'h2304, 3'd5));
    endtask

    task automatic t_outer_stall();
        int n;
        logic [15:0] s;
        s = 16'hD71F;
        stall_en = 1;
        hold_bad = 0; stall_seen = 0;
        start_entry(3'd2, 8'h19, s, 32'hCAFE_0042, 32'h0008_0000, 32'h0004_0010);
        wait_done(n);
        chk(done == 1'b1, "R9", "outer done seen", done, 1);
        chk(log_n == 8, "R6", "outer write count", log_n, 8);
        check_frame(0, 32'h0007_FFF8, s, 32'hCAFE_0042, 8'h19, "R6");
        check_frame(4, 32'h0004_0008, s, 32'hCAFE_0042, 8'h19, "R6");
        chk(sr_out == exp_sr(s, 3'd2), "R5", "outer new sr", sr_out, exp_sr(s, 3'd2));
        chk(msp_out == 32'h0007_FFF8, "R6", "msp result", msp_out, 32'h0007_FFF8);
        chk(isp_out == 32'h0004_0008, "R6", "isp result", isp_out, 32'h0004_0008);
        chk(stall_seen > 0 && hold_bad == 0, "R8", "hold under stall", hold_bad, 0);
        @(negedge clk);
        chk(!done, "R9", "outer done single", done, 0);
        stall_en = 0;
    endtask

    task automatic t_busy_ignore();
        int n;
        stall_en = 0;
        start_entry(3'd3, 8'h21, 16'h0000, 32'h0000_0ABC, 32'h0000_3000, 32'h0000_5000);
        @(negedge clk);
        vector = 8'h99; isp_in = 32'h0000_9000; sr_in = 16'h1000; accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
        wait_done(n);
        chk(log_n == 4, "R11", "no extra writes", log_n, 4);
        chk(vec_addr == 32'h84 && isp_out == 32'h4FF8, "R11", "results from first",
            vec_addr, 32'h84);
        repeat (4) @(negedge clk);
        chk(!busy && log_n == 4, "R11", "no restart after done", log_n, 4);
        chk(msp_out == 32'h3000, "R7", "msp untouched", msp_out, 32'h3000);
    endtask

    task automatic t_boundary();
        int n;
        stall_en = 1;
        hold_bad = 0;
        start_entry(3'd7, 8'hFF, 16'h00FF, 32'hFFFF_0000, 32'h0000_0100, 32'h0000_0008);
        wait_done(n);
        chk(log_n == 4, "R7", "boundary count", log_n, 4);
        check_frame(0, 32'h0, 16'h00FF, 32'hFFFF_0000, 8'hFF, "R2");
        chk(log_d[0] == 16'h03FC, "R3", "max vector offset", log_d[0], 16'h03FC);
        chk(vec_addr == 32'h3FC, "R10", "max vector address", vec_addr, 32'h3FC);
        chk(sr_out == 16'h27FF, "R5", "level 7 mask", sr_out, 16'h27FF);
        chk(hold_bad == 0, "R8", "hold nested stall", hold_bad, 0);
        stall_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_nested_fast();
        t_outer_stall();
        t_busy_ignore();
        t_boundary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule